// File: doc/BRIEF.md
# Event-Driven Power-Gating Task Sequencer

This block is a small always-on controller that powers a fixed chain of hardware micro-tasks up and down in turn. An external trigger starts the chain. Each micro-task, once finished, sends a one-cycle completion pulse. The sequencer then removes power from that task and grants power to the next one. After the last task completes, everything gated goes dark and the sequencer waits for the next trigger.

Alongside the task enables, the sequencer drives a power enable for a shared scratch memory. That memory is powered only while the active task uses it; a per-task usage mask sets this, and by default the first three tasks use it and the fourth does not. A second, persistent memory holds node data that must survive, so its enable is never removed. A busy flag marks the span from an accepted trigger to the processing of the final completion. All enables come straight from flip-flops, so the power switches never see a glitch.

Top module: `ptask_sequencer`

## Requirements
- R1: While `rst_n` is low, every task enable, the scratch memory enable and `busy_o` are 0.
- R2: In idle, an `ext_trig_i` pulse makes task 0's enable (bit 0), the scratch memory enable and `busy_o` go to 1 at the next rising clock edge.
- R3: A completion pulse on `task_done_i[i]` while task i is enabled and i is not the last task clears bit i and sets bit i+1 of `task_pwr_en_o` at the next edge.
- R4: `scratch_mem_en_o` is 1 exactly while a task whose usage mask bit is set is enabled (default mask 4'b0111: tasks 0 to 2 on, task 3 off). It is 0 in idle.
- R5: `persist_mem_en_o` is 1 in every cycle, during reset included.
- R6: A completion pulse from the last task while it is enabled clears all task enables, the scratch enable and `busy_o` at the next edge. A later trigger then starts a new chain.
- R7: At most one bit of `task_pwr_en_o` is 1 in any cycle.
- R8: A completion pulse from a task that is not currently enabled changes no output. This includes pulses that arrive while idle.
- R9: A trigger that arrives while `busy_o` is 1 changes no output and is not remembered once the chain ends.
- R10: `busy_o` is 1 exactly when some task enable is 1, that is, from the accepted trigger until the last completion has been processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_trig_i | input | 1 | External start event, one-cycle pulse |
| task_done_i | input | N_TASKS | Per-task completion pulses |
| task_pwr_en_o | output | N_TASKS | Registered power enable for each task |
| scratch_mem_en_o | output | 1 | Registered power enable for the gated scratch memory |
| persist_mem_en_o | output | 1 | Power enable for the persistent memory, held at 1 |
| busy_o | output | 1 | A chain is in progress |

## Verification
Every accepted event takes effect on the first rising edge after it is presented, and an ignored event takes effect on no edge. So each stimulus cycle has exactly one expected output vector, due one edge later. The driver presents inputs on the falling edge and pushes the expected vector for that step. The monitor pops it a quarter period after the next rising edge, which keeps every comparison one register stage behind its stimulus. Ignored events are checked the same way: the expected vector for that step equals the previous one.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import seq_pkg::*;
#(
  parameter int N_TASKS = 4,
  localparam int IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  phase_e              phase_q,
  input  logic [IW-1:0]       idx_q,
  input  logic                ext_trig,
  input  logic [N_TASKS-1:0]  task_done,
  output phase_e              phase_d,
  output logic [IW-1:0]       idx_d,
  output logic                accept
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_TASKS - 1);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    accept  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (ext_trig) begin
          phase_d = PH_RUN;
          idx_d   = '0;
          accept  = 1'b1;
        end
      end
      PH_RUN: begin
        if (task_done[idx_q]) begin
          accept = 1'b1;
          if (idx_q == LAST_IDX) begin
            phase_d = PH_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        idx_d   = '0;
      end
    endcase
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import seq_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  phase_e        phase_d,
  input  logic [IW-1:0] idx_d,
  output phase_e        phase_q,
  output logic [IW-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (load) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/seq_cmd_reg.sv
module seq_cmd_reg
  import seq_pkg::*;
#(
  parameter int                 N_TASKS  = 4,
  parameter logic [N_TASKS-1:0] MEM1_USE = 4'b0111,
  localparam int IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  phase_e             phase_d,
  input  logic [IW-1:0]      idx_d,
  output logic [N_TASKS-1:0] task_en,
  output logic               mem_en,
  output logic               busy
);
  logic run_d;
  assign run_d = (phase_d == PH_RUN);

  for (genvar i = 0; i < N_TASKS; i++) begin : g_task
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        task_en[i] <= 1'b0;
      end else if (load) begin
        task_en[i] <= run_d && (idx_d == IW'(i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en <= 1'b0;
      busy   <= 1'b0;
    end else if (load) begin
      mem_en <= run_d && MEM1_USE[idx_d];
      busy   <= run_d;
    end
  end

  AST_ONE_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(task_en)); // R7
endmodule

// File: rtl/ptask_sequencer.sv
module ptask_sequencer
  import seq_pkg::*;
#(
  parameter int                 N_TASKS  = 4,
  parameter logic [N_TASKS-1:0] MEM1_USE = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_trig_i,
  input  logic [N_TASKS-1:0] task_done_i,
  output logic [N_TASKS-1:0] task_pwr_en_o,
  output logic               scratch_mem_en_o,
  output logic               persist_mem_en_o,
  output logic               busy_o
);
  localparam int IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1;

  phase_e        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          accept;

  seq_next_state #(.N_TASKS(N_TASKS)) u_next (
    .phase_q   (phase_q),
    .idx_q     (idx_q),
    .ext_trig  (ext_trig_i),
    .task_done (task_done_i),
    .phase_d   (phase_d),
    .idx_d     (idx_d),
    .accept    (accept)
  );

  seq_state_reg #(.IW(IW)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .phase_d (phase_d),
    .idx_d   (idx_d),
    .phase_q (phase_q),
    .idx_q   (idx_q)
  );

  seq_cmd_reg #(.N_TASKS(N_TASKS), .MEM1_USE(MEM1_USE)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .phase_d (phase_d),
    .idx_d   (idx_d),
    .task_en (task_pwr_en_o),
    .mem_en  (scratch_mem_en_o),
    .busy    (busy_o)
  );

  assign persist_mem_en_o = 1'b1;

  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig_i && !busy_o |=> task_pwr_en_o == N_TASKS'(1) && busy_o && scratch_mem_en_o == MEM1_USE[0]); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(task_done_i & task_pwr_en_o)) && !task_pwr_en_o[N_TASKS-1]
      |=> task_pwr_en_o == ($past(task_pwr_en_o) << 1)); // R3
  AST_SCRATCH_USE: assert property (@(posedge clk) disable iff (!rst_n)
    scratch_mem_en_o |-> |(task_pwr_en_o & MEM1_USE)); // R4
  AST_CHAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    task_done_i[N_TASKS-1] && task_pwr_en_o[N_TASKS-1]
      |=> task_pwr_en_o == '0 && !busy_o && !scratch_mem_en_o); // R6
  AST_NO_STRAY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(task_done_i & task_pwr_en_o)) && !(ext_trig_i && !busy_o)
      |=> $stable(task_pwr_en_o) && $stable(scratch_mem_en_o)); // R8
  AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig_i && busy_o && !(|(task_done_i & task_pwr_en_o)) |=> $stable(task_pwr_en_o)); // R9
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (|task_pwr_en_o)); // R10
endmodule

// File: tb/ptask_sequencer_tb.sv
module ptask_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  typedef struct {
    logic [NT-1:0] en;
    logic          mem1;
    logic          mem2;
    logic          busy;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ext_trig_i;
  logic [NT-1:0] task_done_i;
  logic [NT-1:0] task_pwr_en_o;
  logic          scratch_mem_en_o, persist_mem_en_o, busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cur = 0;           // 0 idle, k = task k-1 powered
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptask_sequencer #(.N_TASKS(NT), .MEM1_USE(4'b0111)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_trig_i(ext_trig_i), .task_done_i(task_done_i),
    .task_pwr_en_o(task_pwr_en_o), .scratch_mem_en_o(scratch_mem_en_o),
    .persist_mem_en_o(persist_mem_en_o), .busy_o(busy_o)
  );

  task automatic compare(exp_t e);
    n_cmp++;
    if (task_pwr_en_o !== e.en || scratch_mem_en_o !== e.mem1 ||
        persist_mem_en_o !== e.mem2 || busy_o !== e.busy) begin
      n_bad++;
      $display("FAIL %s: got en=%b m1=%b m2=%b busy=%b, want en=%b m1=%b m2=%b busy=%b",
               e.tag, task_pwr_en_o, scratch_mem_en_o, persist_mem_en_o, busy_o,
               e.en, e.mem1, e.mem2, e.busy);
    end
  endtask

  function automatic exp_t model_out(string tag);
    exp_t e;
    e.en   = (cur == 0) ? '0 : NT'(1) << (cur - 1);
    e.mem1 = (cur >= 1 && cur <= 3);   // tasks 0..2 use scratch memory
    e.mem2 = 1'b1;
    e.busy = (cur != 0);
    e.tag  = tag;
    return e;
  endfunction

  // driver: one stimulus cycle, one expected result
  task automatic step(logic trig, logic [NT-1:0] done, string tag);
    @(negedge clk);
    ext_trig_i  = trig;
    task_done_i = done;
    if (cur == 0) begin
      if (trig) cur = 1;
    end else if (done[cur-1]) begin
      cur = (cur == NT) ? 0 : cur + 1;
    end
    sb.push_back(model_out(tag));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    for (int w = 0; w < 5000; w++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_trig_i = 1'b0; task_done_i = '0;
    repeat (3) @(negedge clk);
    compare(model_out("R1 reset state, R5 persistent on in reset"));
    rst_n = 1'b1;
    step(0, '0,      "R1 idle after reset");
    step(0, 4'b1111, "R8 done pulses while idle ignored");
    step(0, 4'b0001, "R8 done while idle ignored");
    step(1, '0,      "R2 trigger starts task 0");
    step(0, 4'b1110, "R8 done from disabled tasks ignored");
    step(1, '0,      "R9 trigger while busy ignored");
    step(0, '0,      "R7 hold on task 0");
    step(0, 4'b0001, "R3 task 0 -> task 1");
    step(1, 4'b0100, "R9 R8 trigger and stray done ignored");
    step(0, 4'b0010, "R3 task 1 -> task 2, R4 scratch stays on");
    step(0, 4'b0100, "R4 task 3 drops scratch memory");
    step(0, 4'b0111, "R8 stray done during last task");
    step(0, 4'b1000, "R6 last done returns to idle, R10 busy low");
    step(0, '0,      "R9 trigger not queued");
    step(0, '0,      "R5 persistent memory still on");
    step(1, 4'b1111, "R2 trigger with done noise while idle");
    step(0, 4'b1111, "R3 all done bits advance one step only");
    step(0, 4'b1111, "R3 advance to task 2");
    step(0, 4'b1111, "R4 advance to task 3");
    step(1, 4'b1111, "R6 chain end with trigger present");
    step(0, '0,      "R10 idle again");
    step(1, '0,      "R6 restart accepted");
    step(0, 4'b0001, "R3 restart advance");
    step(0, '0,      "R10 busy while task 1 runs");
    @(negedge clk);
    ext_trig_i = 1'b0; task_done_i = '0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule